// File: doc/BRIEF.md
# Power Rail Control Register Bank

This block is the register bank that a serial target writes to switch a set of power rails on and off and pick their output levels. It exposes a simple single-cycle register port (address, write data, write strobe, combinational read data) covering eight byte addresses. The stored bits drive the rail enables, a boost converter enable, two multi-level selects decoded one-hot, and five single-bit level selects.

Three reset sources act on the bank with different scope. The hardware reset pin clears everything, the software reset bit included, and while it is low nothing can be written. Setting the software reset bit clears every other register and keeps them cleared: only that bit still accepts writes until software writes it back to 0. The undervoltage input clears every register except the software reset bit. Address 0 also carries a fixed, read-only version code.

Top module: `pwr_ctl_regbank`

## Requirements
- R1: After the hardware reset pin is released, address 0 reads 8'h20 and addresses 1 to 7 read 8'h00. All enables and single-bit selects are 0, and both one-hot level outputs read 3'b001.
- R2: Address 1 bits [6:0] drive rail_en[6:0] directly. Bit 7 is unused and always reads 0.
- R3: Address 2 bits [7:6] choose the negative rail level and bits [5:4] the high rail level. For each field, code 00 gives one-hot 3'b001, code 01 gives 3'b010, and codes 10 and 11 give 3'b100. Bits [3:0] always read 0.
- R4: Address 3 keeps only bits 7, 6, 5, 2 and 0. These drive lvl_sel[4], [3], [2], [1] and [0] in that order. Every other bit of address 3 always reads 0.
- R5: Address 4 bit 3 drives rail_en[8], bit 2 drives rail_en[7] and bit 0 drives boost_en. All other bits of address 4 always read 0.
- R6: Writes to addresses 5, 6 and 7 change nothing, and reads of those addresses return 8'h00.
- R7: Writing 1 to address 0 bit 0 sets the software reset bit. At the same clock edge, addresses 1 to 4 and all outputs return to their reset values. Address 0 then reads 8'h21.
- R8: While the software reset bit is 1, writes to addresses 1 to 4 are rejected. Writing 0 to address 0 bit 0 releases it, and later writes are accepted again.
- R9: Undervoltage high at a clock edge clears addresses 1 to 4 at that edge and rejects writes to them. The software reset bit keeps its value.
- R10: The hardware reset pin clears all registers and outputs as soon as it goes low, without waiting for a clock. This also cancels a software reset. Its release is synchronized over two clock edges, after which writes are accepted.
- R11: When no write strobe, software reset or undervoltage is active, the stored settings and outputs do not change. Reads have no side effects.
- R12: The version field, address 0 bits [7:5], always reads 3'b001, and bits [4:1] always read 0, whatever value is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| hw_rst_n | input | 1 | Hardware reset pin, active low, asynchronous assertion |
| uv_det | input | 1 | Undervoltage flag, active high |
| wr_stb | input | 1 | Write strobe for one cycle |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| rail_en | output | 9 | Rail on/off enables |
| boost_en | output | 1 | Boost converter enable |
| neg_lvl_oh | output | 3 | One-hot negative rail level |
| pos_lvl_oh | output | 3 | One-hot high rail level |
| lvl_sel | output | 5 | Single-bit level selects |

## Verification
All-ones writes to every address show that only the defined bits are kept. A sweep over all four codes of each address-2 field shows that codes 10 and 11 collapse to one level. Every reset source is applied with the bank full of non-zero settings, so each clear shows up in both the read data and the outputs. Each source is also tried while the software reset bit is set, which tells the preserving undervoltage apart from the cancelling pin reset. Writes attempted during software reset and during undervoltage, followed by read-back, show that the write blocking differs from the clearing.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int CFG_N   = 4;
  localparam logic [2:0] VERSION = 3'b001;

  typedef logic [DATA_W-1:0] byte_t;

  // kept bits of configuration register at address idx+1
  function automatic byte_t cfg_mask(int idx);
    case (idx)
      0:       return 8'h7F;
      1:       return 8'hF0;
      2:       return 8'hE5;
      3:       return 8'h0D;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pwr_reg_core.sv
module pwr_reg_core
  import pwr_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uv_det,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             wdata,
  output byte_t             rdata,
  output byte_t [CFG_N-1:0] cfg_q
);
  logic              srst_q, srst_d;
  logic              hold_clr;
  byte_t [CFG_N-1:0] cfg_d;
  logic [CFG_N-1:0]  cfg_en;
  logic              ctl_wr;

  assign ctl_wr = wr_stb && (addr == '0);

  always_comb begin
    srst_d   = ctl_wr ? wdata[0] : srst_q;
    hold_clr = srst_d || uv_det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= 1'b0;
    else        srst_q <= srst_d;
  end

  for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
    always_comb begin
      cfg_en[g] = hold_clr || (wr_stb && (addr == ADDR_W'(g + 1)));
      cfg_d[g]  = hold_clr ? '0 : (wdata & cfg_mask(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_q[g] <= '0;
      else if (cfg_en[g]) cfg_q[g] <= cfg_d[g];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata = {VERSION, 4'b0000, srst_q};
    else if (int'(addr) <= CFG_N) rdata = cfg_q[int'(addr) - 1];
  end

  assert_srst_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[0]) |=> (cfg_q == '0 && srst_q));

  assert_srst_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_q && wr_stb && addr != '0) |=> $stable(cfg_q));

  assert_uv_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uv_det |=> (cfg_q == '0));

  assert_uv_keeps_srst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_det && !ctl_wr) |=> $stable(srst_q));

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !uv_det) |=> ($stable(cfg_q) && $stable(srst_q)));

  assert_hi_addr_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && int'(addr) > CFG_N && !uv_det && !srst_q) |=> $stable(cfg_q));
endmodule

// File: rtl/pwr_lvl_dec.sv
module pwr_lvl_dec (
  input  logic [1:0] code,
  output logic [2:0] lvl_oh
);
  always_comb begin
    case (code)
      2'b00:   lvl_oh = 3'b001;
      2'b01:   lvl_oh = 3'b010;
      default: lvl_oh = 3'b100;
    endcase
  end
endmodule

// File: rtl/pwr_out_map.sv
module pwr_out_map
  import pwr_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  byte_t [CFG_N-1:0] cfg,
  output logic [8:0]        rail_en,
  output logic              boost_en,
  output logic [2:0]        neg_lvl_oh,
  output logic [2:0]        pos_lvl_oh,
  output logic [4:0]        lvl_sel
);
  logic [1:0][1:0] codes;
  logic [1:0][2:0] lvl_oh;

  assign codes[0] = cfg[1][7:6];
  assign codes[1] = cfg[1][5:4];

  for (genvar g = 0; g < 2; g++) begin : g_dec
    pwr_lvl_dec u_dec (.code(codes[g]), .lvl_oh(lvl_oh[g]));
  end

  assign neg_lvl_oh = lvl_oh[0];
  assign pos_lvl_oh = lvl_oh[1];
  assign rail_en    = {cfg[3][3], cfg[3][2], cfg[0][6:0]};
  assign boost_en   = cfg[3][0];
  assign lvl_sel    = {cfg[2][7], cfg[2][6], cfg[2][5], cfg[2][2], cfg[2][0]};

  for (genvar g = 0; g < CFG_N; g++) begin : g_rsvd
    assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg[g] & ~cfg_mask(g)) == '0));
  end

  assert_lvl_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(neg_lvl_oh) == 1 && $countones(pos_lvl_oh) == 1));
endmodule

// File: rtl/pwr_ctl_regbank.sv
module pwr_ctl_regbank
  import pwr_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              hw_rst_n,
  input  logic              uv_det,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [8:0]        rail_en,
  output logic              boost_en,
  output logic [2:0]        neg_lvl_oh,
  output logic [2:0]        pos_lvl_oh,
  output logic [4:0]        lvl_sel
);
  logic              rst_n_sync;
  byte_t [CFG_N-1:0] cfg_q;

  pwr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .arst_n(hw_rst_n), .rst_n_sync(rst_n_sync)
  );

  pwr_reg_core u_core (
    .clk(clk), .rst_n(rst_n_sync), .uv_det(uv_det), .wr_stb(wr_stb),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cfg_q(cfg_q)
  );

  pwr_out_map u_map (
    .clk(clk), .rst_n(rst_n_sync), .cfg(cfg_q), .rail_en(rail_en),
    .boost_en(boost_en), .neg_lvl_oh(neg_lvl_oh), .pos_lvl_oh(pos_lvl_oh),
    .lvl_sel(lvl_sel)
  );

  assert_hw_rst_clears_R10: assert property (@(posedge clk)
    !hw_rst_n |-> (rail_en == '0 && !boost_en && lvl_sel == '0));
endmodule

// File: tb/pwr_ctl_regbank_tb.sv
`timescale 1ns/1ps
module pwr_ctl_regbank_tb;
  logic       clk = 1'b0;
  logic       hw_rst_n = 1'b0;
  logic       uv_det = 1'b0;
  logic       wr_stb = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [8:0] rail_en;
  logic       boost_en;
  logic [2:0] neg_lvl_oh, pos_lvl_oh;
  logic [4:0] lvl_sel;

  int checks = 0;
  int errors = 0;
  logic rd_vld = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] m1 = 0, m2 = 0, m3 = 0, m4 = 0;

  always #5 clk = ~clk;

  pwr_ctl_regbank u_dut (
    .clk(clk), .hw_rst_n(hw_rst_n), .uv_det(uv_det), .wr_stb(wr_stb),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rail_en(rail_en),
    .boost_en(boost_en), .neg_lvl_oh(neg_lvl_oh), .pos_lvl_oh(pos_lvl_oh),
    .lvl_sel(lvl_sel)
  );

  // monitor: pops expected read values and compares away from the edge
  always @(negedge clk) begin
    if (rd_vld) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_stb = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_stb = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    addr = a; rd_vld = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); #1;
    rd_vld = 1'b0;
  endtask

  function automatic logic [2:0] lvl(input logic [1:0] c);
    return (c == 2'b00) ? 3'b001 : (c == 2'b01) ? 3'b010 : 3'b100;
  endfunction

  task automatic chk_out(input string t);
    logic [8:0] e_rail;
    logic [4:0] e_sel;
    e_rail = {m4[3], m4[2], m1[6:0]};
    e_sel  = {m3[7], m3[6], m3[5], m3[2], m3[0]};
    @(negedge clk);
    checks++;
    if (rail_en !== e_rail || boost_en !== m4[0] || neg_lvl_oh !== lvl(m2[7:6]) ||
        pos_lvl_oh !== lvl(m2[5:4]) || lvl_sel !== e_sel) begin
      errors++;
      $display("FAIL %s: outputs actual=%h/%b/%b/%b/%h expected=%h/%b/%b/%b/%h", t,
               rail_en, boost_en, neg_lvl_oh, pos_lvl_oh, lvl_sel,
               e_rail, m4[0], lvl(m2[7:6]), lvl(m2[5:4]), e_sel);
    end
  endtask

  task automatic uv_pulse();
    @(posedge clk); #1; uv_det = 1'b1;
    @(posedge clk); #1; uv_det = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 hw_rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    rd(3'd0, 8'h20, "R1 addr0");
    for (int a = 1; a < 8; a++) rd(3'(a), 8'h00, "R1 cfg");
    chk_out("R1 outputs");

    // R2 rail enables
    wr(3'd1, 8'hFF); m1 = 8'h7F;
    rd(3'd1, 8'h7F, "R2 bit7 dropped");
    chk_out("R2 all on");
    wr(3'd1, 8'h2A); m1 = 8'h2A;
    chk_out("R2 pattern");

    // R3 level codes
    for (int c = 0; c < 4; c++) begin
      logic [7:0] d;
      d = {2'(c), 2'(3 - c), 4'hF};
      wr(3'd2, d); m2 = {2'(c), 2'(3 - c), 4'h0};
      rd(3'd2, m2, "R3 read");
      chk_out("R3 decode");
    end

    // R4 single-bit selects
    wr(3'd3, 8'hFF); m3 = 8'hE5;
    rd(3'd3, 8'hE5, "R4 mask");
    chk_out("R4 all set");
    wr(3'd3, 8'h25); m3 = 8'h25;
    chk_out("R4 pattern");

    // R5 second enable register
    wr(3'd4, 8'hFF); m4 = 8'h0D;
    rd(3'd4, 8'h0D, "R5 mask");
    chk_out("R5 enables");

    // R6 high addresses ignored
    for (int a = 5; a < 8; a++) wr(3'(a), 8'hFF);
    for (int a = 5; a < 8; a++) rd(3'(a), 8'h00, "R6 read zero");
    rd(3'd1, m1, "R6 no side effect");
    chk_out("R6 outputs unchanged");

    // R12 version read-only
    wr(3'd0, 8'hFE);
    rd(3'd0, 8'h20, "R12 version");

    // R11 reads leave state alone
    chk_out("R11 stable across reads");

    // R7 software reset clears
    wr(3'd0, 8'h01); m1 = 0; m2 = 0; m3 = 0; m4 = 0;
    rd(3'd0, 8'h21, "R7 srst set");
    rd(3'd2, 8'h00, "R7 cleared");
    chk_out("R7 outputs cleared");

    // R8 writes blocked then released
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h00, "R8 blocked");
    chk_out("R8 outputs blocked");
    wr(3'd0, 8'h00);
    rd(3'd0, 8'h20, "R8 released");
    wr(3'd1, 8'h0F); m1 = 8'h0F;
    rd(3'd1, 8'h0F, "R8 accepted");

    // R9 undervoltage
    wr(3'd4, 8'h0D); m4 = 8'h0D;
    chk_out("R9 before uv");
    uv_pulse(); m1 = 0; m4 = 0;
    rd(3'd1, 8'h00, "R9 cleared 1");
    rd(3'd4, 8'h00, "R9 cleared 4");
    rd(3'd0, 8'h20, "R9 srst stays 0");
    chk_out("R9 outputs");
    @(posedge clk); #1;
    uv_det = 1'b1; wr_stb = 1'b1; addr = 3'd2; wdata = 8'hF0;
    @(posedge clk); #1;
    wr_stb = 1'b0; uv_det = 1'b0;
    rd(3'd2, 8'h00, "R9 write rejected");
    wr(3'd0, 8'h01);
    uv_pulse();
    rd(3'd0, 8'h21, "R9 srst kept");
    wr(3'd0, 8'h00);

    // R10 hardware reset cancels soft reset
    wr(3'd1, 8'h55); m1 = 8'h55;
    chk_out("R10 before");
    wr(3'd0, 8'h01); m1 = 0;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h55); m1 = 8'h55;
    @(posedge clk); #3;
    hw_rst_n = 1'b0; m1 = 0;
    #1;
    checks++;
    if (rail_en !== 9'h000) begin
      errors++;
      $display("FAIL R10 async clear: rail_en actual=%h expected=000", rail_en);
    end
    wr(3'd0, 8'h01);
    repeat (2) @(posedge clk);
    #1 hw_rst_n = 1'b1;
    repeat (3) @(posedge clk);
    rd(3'd0, 8'h20, "R10 srst cancelled");
    wr(3'd1, 8'h33); m1 = 8'h33;
    rd(3'd1, 8'h33, "R10 writes accepted");
    chk_out("R10 outputs");

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule